// File: doc/BRIEF.md
# Iterative Integer Divide/Remainder Unit

This block computes the quotient or the remainder of two integer operands of parameter width `XLEN` (64 by default), in signed or unsigned interpretation, and also in a half-width "word" mode that reads only the low `XLEN/2` bits of each operand and sign-extends the half-width result back to full width. A request is presented with `req_valid` and is taken on a clock edge where `req_ready` is high. The block never traps. A zero divisor and the most-negative-divided-by-minus-one overflow are detected as the request is taken and return their defined values on the next cycle. All other requests run a radix-2 restoring loop on the operand magnitudes, with one quotient bit per cycle.

Back-pressure rules: `req_ready` is low for the whole iteration, and a request offered while it is low is not taken and has no effect. `req_ready` is high again in the cycle that carries `rsp_valid`, so a new request can be taken in that cycle. The response side has no ready input. `rsp_valid` is a one-cycle pulse per operation, and `rsp_data` keeps its value until the next operation completes.

Top module: `div_unit`

## Requirements
- R1: For a nonzero divisor, the quotient rounds toward zero. Operands are read as two's complement when `req_signed` is 1 and as unsigned when it is 0.
- R2: For a nonzero divisor, the remainder satisfies dividend = quotient*divisor + remainder, and its sign follows the dividend (or it is zero).
- R3: With a zero divisor, the quotient result is all ones, in both signed and unsigned modes.
- R4: With a zero divisor, the remainder result equals the dividend. In word mode this is the low half of the dividend, sign-extended.
- R5: In signed mode, the most negative value divided by -1 gives the most negative value as its quotient (in word mode, the sign-extended half-width minimum).
- R6: In that signed overflow case, the remainder result is zero.
- R7: With `req_word`=1, only bits [XLEN/2-1:0] of each operand are used, and bits [XLEN-1:XLEN/2] of `rsp_data` copy bit XLEN/2-1. This holds for unsigned word operations too.
- R8: Count the accepting edge as edge 1. `rsp_valid` is seen after edge 1 for zero-divisor and overflow cases, after edge XLEN+1 for full-width requests, and after edge XLEN/2+1 for word requests.
- R9: `req_ready` is low while an iteration is in progress. A `req_valid` offered then is not accepted and does not change the result in progress.
- R10: `rsp_valid` is high for one cycle per operation, and `rsp_data` does not change in any cycle where `rsp_valid` is low.
- R11: After reset, `req_ready`=1, `rsp_valid`=0 and `rsp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_dividend | input | XLEN | Dividend |
| req_divisor | input | XLEN | Divisor |
| req_signed | input | 1 | 1: two's complement operands |
| req_word | input | 1 | 1: half-width operation, sign-extended result |
| req_rem | input | 1 | 1: return remainder, 0: return quotient |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | XLEN | Result, held until the next completion |

## Verification
Two events can fall in the same cycle: a completion pulse, and the acceptance of the next request. The bench issues each request in the very cycle in which it sees `rsp_valid` for the previous one. Each result and each latency is then judged against arithmetic done in the bench, so a taken request that disturbs the finishing one, or a missed request, shows up as a wrong value or a stalled response. The bench also offers requests while the unit is busy, and checks that they are refused and leave the running result untouched.

// File: rtl/div_pkg.sv
package div_pkg;
  // Control captured when an iterative request is taken
  typedef struct packed {
    logic neg_quot;   // quotient must be negated at the end
    logic neg_rem;    // remainder must be negated at the end
    logic word;       // half-width result, sign-extend
    logic want_rem;   // return remainder instead of quotient
  } div_ctl_t;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: half-width extraction, sign handling, special cases
module div_prep #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  input  logic            is_signed,
  input  logic            is_word,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg_a,
  output logic            neg_b,
  output logic            by_zero,
  output logic            overflow,
  output logic [XLEN-1:0] spec_quot,
  output logic [XLEN-1:0] spec_rem
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] MIN_FULL = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] MIN_WORD = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  logic [XLEN-1:0] ext_a, ext_b, sx_a, sx_b;

  always_comb begin
    sx_a = {{HALF{dividend[HALF-1]}}, dividend[HALF-1:0]};
    sx_b = {{HALF{divisor[HALF-1]}}, divisor[HALF-1:0]};
    if (is_word) begin
      ext_a = is_signed ? sx_a : {{HALF{1'b0}}, dividend[HALF-1:0]};
      ext_b = is_signed ? sx_b : {{HALF{1'b0}}, divisor[HALF-1:0]};
    end else begin
      ext_a = dividend;
      ext_b = divisor;
    end
    neg_a    = is_signed & ext_a[XLEN-1];
    neg_b    = is_signed & ext_b[XLEN-1];
    mag_a    = neg_a ? (~ext_a + 1'b1) : ext_a;
    mag_b    = neg_b ? (~ext_b + 1'b1) : ext_b;
    by_zero  = (ext_b == '0);
    overflow = is_signed & (ext_b == '1) &
               (ext_a == (is_word ? MIN_WORD : MIN_FULL));
    // zero divisor: all ones / dividend; overflow: dividend (the minimum) / zero
    spec_quot = by_zero ? '1 : ext_a;
    spec_rem  = by_zero ? (is_word ? sx_a : dividend) : '0;
  end
endmodule

// File: rtl/div_core.sv
// Radix-2 restoring iteration on magnitudes, one quotient bit per cycle
module div_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            word,
  input  logic [XLEN-1:0] mag_a,
  input  logic [XLEN-1:0] mag_b,
  output logic            busy,
  output logic            last,
  output logic [XLEN-1:0] q_next,
  output logic [XLEN-1:0] r_next
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  logic [XLEN-1:0] q_r, rem_r, den_r;
  logic [CW-1:0]   cnt_r;
  logic [XLEN:0]   shifted, diff;

  always_comb begin
    shifted = {rem_r, q_r[XLEN-1]};
    diff    = shifted - {1'b0, den_r};
    q_next  = {q_r[XLEN-2:0], ~diff[XLEN]};
    r_next  = diff[XLEN] ? shifted[XLEN-1:0] : diff[XLEN-1:0];
  end

  assign busy = (cnt_r != '0);
  assign last = (cnt_r == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      rem_r <= '0;
      den_r <= '0;
      cnt_r <= '0;
    end else if (load) begin
      q_r   <= word ? (mag_a << HALF) : mag_a;
      rem_r <= '0;
      den_r <= mag_b;
      cnt_r <= word ? CW'(HALF) : CW'(XLEN);
    end else if (busy) begin
      q_r   <= q_next;
      rem_r <= r_next;
      cnt_r <= cnt_r - CW'(1);
    end
  end

  // R2: partial remainder always stays below the divisor during iteration
  a_r2_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_r < den_r));
endmodule

// File: rtl/div_unit.sv
module div_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_dividend,
  input  logic [XLEN-1:0] req_divisor,
  input  logic            req_signed,
  input  logic            req_word,
  input  logic            req_rem,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data
);
  import div_pkg::*;
  localparam int HALF = XLEN / 2;
  localparam int LW   = $clog2(XLEN + 2) + 1;
  localparam logic [XLEN-1:0] MIN_FULL = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] MIN_WORD = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  logic [XLEN-1:0] mag_a, mag_b, spec_quot, spec_rem, q_next, r_next;
  logic            neg_a, neg_b, by_zero, overflow;
  logic            busy, last, accept, special;
  div_ctl_t        ctl_r;
  logic [XLEN-1:0] q_fix, r_fix, pick, final_val;

  div_prep #(.XLEN(XLEN)) u_prep (
    .dividend(req_dividend), .divisor(req_divisor),
    .is_signed(req_signed), .is_word(req_word),
    .mag_a(mag_a), .mag_b(mag_b), .neg_a(neg_a), .neg_b(neg_b),
    .by_zero(by_zero), .overflow(overflow),
    .spec_quot(spec_quot), .spec_rem(spec_rem)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign special   = by_zero || overflow;

  div_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept && !special), .word(req_word),
    .mag_a(mag_a), .mag_b(mag_b), .busy(busy), .last(last),
    .q_next(q_next), .r_next(r_next)
  );

  always_comb begin
    q_fix     = ctl_r.neg_quot ? (~q_next + 1'b1) : q_next;
    r_fix     = ctl_r.neg_rem  ? (~r_next + 1'b1) : r_next;
    pick      = ctl_r.want_rem ? r_fix : q_fix;
    final_val = ctl_r.word ? {{HALF{pick[HALF-1]}}, pick[HALF-1:0]} : pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (last) begin
        rsp_valid <= 1'b1;
        rsp_data  <= final_val;
      end else if (accept && special) begin
        rsp_valid <= 1'b1;
        rsp_data  <= req_rem ? spec_rem : spec_quot;
      end
      if (accept) begin
        ctl_r.neg_quot <= neg_a ^ neg_b;
        ctl_r.neg_rem  <= neg_a;
        ctl_r.word     <= req_word;
        ctl_r.want_rem <= req_rem;
      end
    end
  end

  // Observation state for the assertions, derived from the raw request pins
  logic [LW-1:0] chk_lat, chk_exp;
  logic          chk_zero, chk_ovf, chk_rem, chk_word;
  logic          raw_zero, raw_ovf;

  always_comb begin
    raw_zero = req_word ? (req_divisor[HALF-1:0] == '0) : (req_divisor == '0);
    raw_ovf  = req_signed && (req_word
      ? ((req_divisor[HALF-1:0] == '1) && (req_dividend[HALF-1:0] == MIN_FULL[XLEN-1:HALF]))
      : ((req_divisor == '1) && (req_dividend == MIN_FULL)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_lat <= '0; chk_exp <= '0;
      chk_zero <= 1'b0; chk_ovf <= 1'b0; chk_rem <= 1'b0; chk_word <= 1'b0;
    end else if (accept) begin
      chk_lat  <= LW'(1);
      chk_exp  <= (raw_zero || raw_ovf) ? LW'(1) : (req_word ? LW'(HALF + 1) : LW'(XLEN + 1));
      chk_zero <= raw_zero;
      chk_ovf  <= raw_ovf;
      chk_rem  <= req_rem;
      chk_word <= req_word;
    end else if (!req_ready) begin
      chk_lat <= chk_lat + LW'(1);
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (chk_lat == chk_exp));
  a_r3_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && chk_zero && !chk_rem) |-> (rsp_data == '1));
  a_r5_ovf_quot: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && chk_ovf && !chk_rem) |-> (rsp_data == (chk_word ? MIN_WORD : MIN_FULL)));
  a_r6_ovf_rem: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && chk_ovf && chk_rem) |-> (rsp_data == '0));
  a_r7_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && chk_word) |-> (rsp_data[XLEN-1:HALF] == {HALF{rsp_data[HALF-1]}}));
  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_valid || !req_ready));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_data));
endmodule

// File: tb/tb_div_unit.sv
`timescale 1ns/1ps
module tb_div_unit;
  localparam int XLEN = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_signed = 1'b0, req_word = 1'b0, req_rem = 1'b0;
  logic [XLEN-1:0] req_dividend = '0, req_divisor = '0;
  logic req_ready, rsp_valid;
  logic [XLEN-1:0] rsp_data;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  div_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dividend(req_dividend), .req_divisor(req_divisor),
    .req_signed(req_signed), .req_word(req_word), .req_rem(req_rem),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic longint as_int(input logic [7:0] v, input int wd, input bit s);
    longint m = (longint'(1) << wd) - 1;
    longint x = longint'(v) & m;
    if (s && ((x >> (wd - 1)) & 1) == 1) x = x - (longint'(1) << wd);
    return x;
  endfunction

  function automatic bit is_special(input logic [7:0] a, b, input bit s, w);
    int wd = w ? 4 : 8;
    longint av = as_int(a, wd, s), bv = as_int(b, wd, s);
    return (bv == 0) || (s && bv == -1 && av == -(longint'(1) << (wd - 1)));
  endfunction

  function automatic logic [7:0] ref_div(input logic [7:0] a, b, input bit s, w, r);
    int wd = w ? 4 : 8;
    longint m = (longint'(1) << wd) - 1;
    longint av = as_int(a, wd, s), bv = as_int(b, wd, s);
    longint qv, rv, res;
    if (bv == 0) begin qv = -1; rv = av; end
    else if (s && bv == -1 && av == -(longint'(1) << (wd - 1))) begin qv = av; rv = 0; end
    else begin qv = av / bv; rv = av % bv; end
    res = (r ? rv : qv) & m;
    if (((res >> (wd - 1)) & 1) == 1) res = res | ~m;
    return res[7:0];
  endfunction

  function automatic string tag(input logic [7:0] a, b, input bit s, w, r);
    int wd = w ? 4 : 8;
    longint bv = as_int(b, wd, s);
    if (bv == 0) return r ? "R4" : "R3";
    if (is_special(a, b, s, w)) return r ? "R6" : "R5";
    if (w) return "R7";
    return r ? "R2" : "R1";
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the negedge where rsp_valid is seen
  task automatic run_op(input logic [7:0] a, b, input bit s, w, r, input bit disturb);
    int lat;
    logic [7:0] exp_v = ref_div(a, b, s, w, r);
    int exp_lat = is_special(a, b, s, w) ? 1 : (w ? 5 : 9);
    check(req_ready === 1'b1, "R9", req_ready, 1);
    req_valid = 1'b1; req_dividend = a; req_divisor = b;
    req_signed = s; req_word = w; req_rem = r;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (rsp_valid !== 1'b1 && lat < 40) begin
      if (disturb && lat <= 3) begin
        // R9: offered while busy, must be refused and leave the result alone
        check(req_ready === 1'b0, "R9", req_ready, 0);
        req_valid = 1'b1; req_dividend = 8'h05; req_divisor = 8'h01;
        req_rem = ~r;
      end
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end
    check(rsp_data === exp_v, tag(a, b, s, w, r), rsp_data, exp_v);
    check(lat == exp_lat, "R8", lat, exp_lat);
  endtask

  // R10: pulse ends and data holds when no new request is offered
  task automatic check_hold();
    logic [7:0] prev = rsp_data;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10", rsp_valid, 0);
    check(rsp_data === prev, "R10", rsp_data, prev);
    repeat (2) @(negedge clk);
    check(rsp_data === prev, "R10", rsp_data, prev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] dlist [12];
    logic [7:0] alist [5];
    dlist = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h10,
              8'h7F, 8'h80, 8'hFF, 8'hFE, 8'hF9};
    alist = '{8'h80, 8'h7F, 8'hFF, 8'h01, 8'h00};
    repeat (3) @(negedge clk);
    // R11: reset state
    check(req_ready === 1'b1, "R11", req_ready, 1);
    check(rsp_valid === 1'b0, "R11", rsp_valid, 0);
    check(rsp_data === 8'h00, "R11", rsp_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Word mode: exhaustive over the low halves, with junk in the upper halves (R7)
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            run_op({4'((a * 3 + b) & 15), 4'(a)}, {4'((b * 5 + 9) & 15), 4'(b)},
                   s[0], 1'b1, r[0], 1'b0);
    check_hold();

    // Full width sweep (R1, R2, R3, R4); back-to-back issue on the done cycle
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++)
        for (int a = 0; a < 256; a += 5)
          for (int k = 0; k < 12; k++)
            run_op(8'(a), dlist[k], s[0], 1'b0, r[0], 1'b0);
    check_hold();

    // Corner dividends, including the signed overflow pair (R5, R6)
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++)
        for (int i = 0; i < 5; i++)
          for (int k = 0; k < 12; k++)
            run_op(alist[i], dlist[k], s[0], 1'b0, r[0], 1'b0);
    check_hold();

    // Requests offered while busy are ignored (R9)
    run_op(8'd100, 8'd7, 1'b1, 1'b0, 1'b0, 1'b1);
    run_op(8'h9C, 8'h07, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op(8'h0B, 8'h03, 1'b0, 1'b1, 1'b0, 1'b1);
    check_hold();

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule